// File: doc/BRIEF.md
# Serial LED Display Write Controller

This block is the host-side driver for a four-character, 5x7 dot-matrix serial LED display. It accepts three kinds of request: re-initialise the display, write one control byte, or write a full frame of four characters given as twenty column bytes. Each request becomes a write cycle on the display's four-wire serial port: a register-select line, an active-low chip enable, a serial clock and a serial data line. Every minimum setup, hold and pulse width is derived from nanosecond parameters and rounded up to whole system-clock cycles.

When reset is released, the block starts up on its own. It drives the display's reset output low for at least the minimum reset time. It then clears all 160 dot bits to zero and loads control word 0 with the brightness input and the sleep bit released. A caller sees `busy` while a sequence runs and a one-cycle `done` pulse when it completes. With the default 5 ns system clock, the derived counts are: serial clock high 16 cycles, low 16 cycles, chip-enable setup 7, chip-enable hold 4, select setup 2, reset pulse 10.

Top module: `disp_wr_ctrl`

## Requirements
- R1: While `rst_n` is low, `disp_rst_n` is low, `disp_ce_n` is high, `disp_clk` is high, `done` is low and `busy` is high.
- R2: After reset release, `disp_rst_n` stays low for at least ceil(T_RST_NS/SYS_PERIOD_NS) cycles. It then rises, and exactly two writes follow: first a dot write (select low) of 160 zero bits, then a control write (select high) of the byte {0, 1, 00, bright[3:0]}, where bit 7 = 0 addresses control word 0 and bit 6 = 1 releases sleep.
- R3: `disp_rs` reaches its final level at least ceil(T_RS_SU_NS/period) cycles before `disp_ce_n` falls, and it does not change while `disp_ce_n` is low.
- R4: The first rising `disp_clk` edge after `disp_ce_n` falls comes at least ceil(T_CE_SU_NS/period) cycles after the fall. `disp_ce_n` rises no sooner than ceil(T_CE_HD_NS/period) cycles after the last rising edge.
- R5: Every high phase of `disp_clk` lasts at least ceil(T_CLK_HI_NS/period) cycles, and every low phase lasts at least ceil(T_CLK_LO_NS/period) cycles.
- R6: `disp_din` changes only while `disp_clk` is low, so it is stable across each rising edge and through the high phase.
- R7: After `disp_ce_n` rises, `disp_clk` makes exactly one low pulse with `disp_ce_n` high. This latch pulse occurs once per write, and `disp_clk` never falls while the block is idle.
- R8: A frame write (`req_kind` = 2) sends 160 bits with select low. The bit for column c and row r is `req_cols[c*8+r]`, where row 0 is the unused bottom row and row 1 is the lowest visible pixel. Column 0 (leftmost) is sent first, and each column is sent from row 7 down to row 0.
- R9: A control write (`req_kind` = 1) sends the 8 bits of `req_ctl` most significant bit first, with select high.
- R10: A request is taken only in a cycle where `busy` is low. A request raised while `busy` is high is dropped. `req_kind` = 3 is a no-op that starts nothing.
- R11: `busy` is high from the cycle after a request is taken until completion. `done` is high for exactly one cycle, in which `busy` is already low.
- R12: An init request (`req_kind` = 0) repeats the whole R2 sequence, using the `bright` value captured when the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 0 init, 1 control byte, 2 frame, 3 no-op |
| req_ctl | input | 8 | Control byte for kind 1 |
| req_cols | input | 160 | Frame, column c row r at bit c*8+r |
| bright | input | 4 | Brightness for control word 0 at start-up |
| disp_rst_n | output | 1 | Reset to the display, active low |
| disp_rs | output | 1 | Register select: 0 dots, 1 control |
| disp_ce_n | output | 1 | Chip enable, active low |
| disp_clk | output | 1 | Serial clock |
| disp_din | output | 1 | Serial data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the bound checker enforces the waveform rules: select stable under an active enable, data moving only in the clock's low phase, the minimum clock phase widths, chip-enable setup before a rising edge, chip enable held high during the display reset, and the shape of `done`. What goes on the wire cannot be shown by a property. That covers the start-up order, the bit order of frames and control bytes, latch pulses matching writes, requests dropped while busy, and re-initialisation with a new brightness. The bench shows these by decoding the serial stream and comparing it with streams it computes from the requirements.

// File: rtl/disp_wr_pkg.sv
// Shared types and helpers for the serial display write controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package disp_wr_pkg;

    typedef enum logic [1:0] {
        REQ_INIT  = 2'd0,
        REQ_CTRL  = 2'd1,
        REQ_FRAME = 2'd2,
        REQ_NOP   = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_CTRL  = 2'd1,
        SRC_FRAME = 2'd2
    } src_mode_t;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_RSTPULSE,
        ST_RSSET,
        ST_CEFALL,
        ST_BITLO,
        ST_BITHI,
        ST_CERISE,
        ST_LATCH,
        ST_RECOVER,
        ST_IDLE
    } seq_state_t;

    typedef enum logic [1:0] {
        JOB_CLEAR = 2'd0,
        JOB_CW0   = 2'd1,
        JOB_USER  = 2'd2
    } job_t;

    // Round a nanosecond minimum up to whole cycles, never below one.
    function automatic int ns_to_cyc(input int ns, input int per);
        int r;
        r = (ns + per - 1) / per;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/disp_wr_timer.sv
// Phase timer: loaded with (length-1) on entry to a phase, counts down,
// and reports expiry when it reaches zero.
// Assumes: the loader never asks for a zero-length phase.
module disp_wr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/disp_wr_bitsrc.sv
// Bit source: captures one write's payload in wire order (zeros, a control
// byte MSB first, or a frame column by column, top row first) and hands it
// out one bit per shift.
// Assumes: FRAME_BITS > CTRL_BITS; load and shift never coincide.
module disp_wr_bitsrc
    import disp_wr_pkg::*;
#(
    parameter int N_COLS    = 20,
    parameter int ROWS      = 8,
    parameter int CTRL_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  src_mode_t                   mode,
    input  logic [CTRL_BITS-1:0]        ctl_byte,
    input  logic [N_COLS*ROWS-1:0]      cols,
    input  logic                        shift,
    output logic                        bit_out,
    output logic                        bit_next,
    output logic                        last
);

    localparam int FRAME_BITS = N_COLS * ROWS;
    localparam int CW         = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] frame_ord;
    logic [FRAME_BITS-1:0] ctrl_ord;
    logic [FRAME_BITS-1:0] sreg;
    logic [CW-1:0]         remain;

    // Frame reorder: within each column the top row leaves first.
    for (genvar gc = 0; gc < N_COLS; gc++) begin : g_col
        for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
            assign frame_ord[gc*ROWS + gr] = cols[gc*ROWS + (ROWS - 1 - gr)];
        end
    end

    // Control reorder: most significant bit leaves first.
    for (genvar gb = 0; gb < CTRL_BITS; gb++) begin : g_ctl
        assign ctrl_ord[gb] = ctl_byte[CTRL_BITS - 1 - gb];
    end
    assign ctrl_ord[FRAME_BITS-1:CTRL_BITS] = '0;

    // Payload register: capture on load, drop the sent bit on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            remain <= '0;
        end else if (load) begin
            case (mode)
                SRC_CTRL: begin
                    sreg   <= ctrl_ord;
                    remain <= CW'(CTRL_BITS);
                end
                SRC_FRAME: begin
                    sreg   <= frame_ord;
                    remain <= CW'(FRAME_BITS);
                end
                default: begin
                    sreg   <= '0;
                    remain <= CW'(FRAME_BITS);
                end
            endcase
        end else if (shift && remain != '0) begin
            sreg   <= sreg >> 1;
            remain <= remain - 1'b1;
        end
    end

    assign bit_out  = sreg[0];
    assign bit_next = sreg[1];
    assign last     = (remain == CW'(1));

endmodule

// File: rtl/disp_wr_seq.sv
// Write sequencer: runs the display reset pulse, the start-up pair of writes
// and user writes, and shapes select, enable, serial clock and data in
// phases timed by the phase timer.
// Assumes: all phase lengths are at least one cycle; outputs are registered.
module disp_wr_seq
    import disp_wr_pkg::*;
#(
    parameter int TW         = 8,
    parameter int LEN_RST    = 10,
    parameter int LEN_RS_SU  = 2,
    parameter int LEN_CEFALL = 7,
    parameter int LEN_LO     = 16,
    parameter int LEN_HI     = 16,
    parameter int LEN_CERISE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  req_kind_t     req_kind,
    input  logic [7:0]    req_ctl,
    input  logic [3:0]    bright,
    input  logic          tmr_expired,
    input  logic          src_bit,
    input  logic          src_bit_next,
    input  logic          src_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          src_load,
    output src_mode_t     src_mode,
    output logic [7:0]    src_byte,
    output logic          src_shift,
    output logic          disp_rst_n,
    output logic          disp_rs,
    output logic          disp_ce_n,
    output logic          disp_clk,
    output logic          disp_din,
    output logic          busy,
    output logic          done
);

    seq_state_t state, nxt;
    job_t       job, job_nxt;
    logic [3:0] bright_q, bright_nxt;
    logic       rstn_q, rstn_nxt;
    logic       rs_q, rs_nxt;
    logic       ce_q, ce_nxt;
    logic       clk_q, clk_nxt;
    logic       din_q, din_nxt;
    logic       done_q, done_nxt;
    logic [7:0] init_byte;

    // Control word 0: select bit clear, sleep released, brightness in low nibble.
    assign init_byte = {1'b0, 1'b1, 2'b00, bright_q};

    // Next-state, timer loads and waveform levels for each phase.
    always_comb begin
        nxt        = state;
        job_nxt    = job;
        bright_nxt = bright_q;
        rstn_nxt   = rstn_q;
        rs_nxt     = rs_q;
        ce_nxt     = ce_q;
        clk_nxt    = clk_q;
        din_nxt    = din_q;
        done_nxt   = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        src_load   = 1'b0;
        src_mode   = SRC_ZERO;
        src_byte   = req_ctl;
        src_shift  = 1'b0;
        case (state)
            ST_BOOT: begin
                rstn_nxt = 1'b0;
                nxt      = ST_RSTPULSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(LEN_RST - 1);
            end
            ST_RSTPULSE: begin
                if (tmr_expired) begin
                    rstn_nxt = 1'b1;
                    src_load = 1'b1;
                    src_mode = SRC_ZERO;
                    job_nxt  = JOB_CLEAR;
                    rs_nxt   = 1'b0;
                    nxt      = ST_RSSET;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_RS_SU - 1);
                end
            end
            ST_RSSET: begin
                if (tmr_expired) begin
                    ce_nxt   = 1'b0;
                    nxt      = ST_CEFALL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_CEFALL - 1);
                end
            end
            ST_CEFALL: begin
                if (tmr_expired) begin
                    clk_nxt  = 1'b0;
                    din_nxt  = src_bit;
                    nxt      = ST_BITLO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_LO - 1);
                end
            end
            ST_BITLO: begin
                if (tmr_expired) begin
                    clk_nxt  = 1'b1;
                    nxt      = ST_BITHI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_HI - 1);
                end
            end
            ST_BITHI: begin
                if (tmr_expired) begin
                    src_shift = 1'b1;
                    tmr_load  = 1'b1;
                    if (src_last) begin
                        ce_nxt  = 1'b1;
                        nxt     = ST_CERISE;
                        tmr_val = TW'(LEN_CERISE - 1);
                    end else begin
                        clk_nxt = 1'b0;
                        din_nxt = src_bit_next;
                        nxt     = ST_BITLO;
                        tmr_val = TW'(LEN_LO - 1);
                    end
                end
            end
            ST_CERISE: begin
                if (tmr_expired) begin
                    clk_nxt  = 1'b0;
                    nxt      = ST_LATCH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_LO - 1);
                end
            end
            ST_LATCH: begin
                if (tmr_expired) begin
                    clk_nxt  = 1'b1;
                    nxt      = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LEN_HI - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) begin
                    if (job == JOB_CLEAR) begin
                        job_nxt  = JOB_CW0;
                        src_load = 1'b1;
                        src_mode = SRC_CTRL;
                        src_byte = init_byte;
                        rs_nxt   = 1'b1;
                        nxt      = ST_RSSET;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LEN_RS_SU - 1);
                    end else begin
                        done_nxt = 1'b1;
                        nxt      = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (req_valid) begin
                    case (req_kind)
                        REQ_INIT: begin
                            bright_nxt = bright;
                            rstn_nxt   = 1'b0;
                            nxt        = ST_BOOT;
                        end
                        REQ_CTRL: begin
                            src_load = 1'b1;
                            src_mode = SRC_CTRL;
                            job_nxt  = JOB_USER;
                            rs_nxt   = 1'b1;
                            nxt      = ST_RSSET;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(LEN_RS_SU - 1);
                        end
                        REQ_FRAME: begin
                            src_load = 1'b1;
                            src_mode = SRC_FRAME;
                            job_nxt  = JOB_USER;
                            rs_nxt   = 1'b0;
                            nxt      = ST_RSSET;
                            tmr_load = 1'b1;
                            tmr_val  = TW'(LEN_RS_SU - 1);
                        end
                        default: ;
                    endcase
                end
            end
            default: nxt = ST_BOOT;
        endcase
    end

    // State and output registers; reset parks the display in its reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_BOOT;
            job      <= JOB_CLEAR;
            bright_q <= bright;
            rstn_q   <= 1'b0;
            rs_q     <= 1'b0;
            ce_q     <= 1'b1;
            clk_q    <= 1'b1;
            din_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state    <= nxt;
            job      <= job_nxt;
            bright_q <= bright_nxt;
            rstn_q   <= rstn_nxt;
            rs_q     <= rs_nxt;
            ce_q     <= ce_nxt;
            clk_q    <= clk_nxt;
            din_q    <= din_nxt;
            done_q   <= done_nxt;
        end
    end

    assign disp_rst_n = rstn_q;
    assign disp_rs    = rs_q;
    assign disp_ce_n  = ce_q;
    assign disp_clk   = clk_q;
    assign disp_din   = din_q;
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;

endmodule

// File: rtl/disp_wr_ctrl.sv
// Top of the serial display write controller: derives phase lengths in
// system-clock cycles from nanosecond minimums and wires the sequencer,
// phase timer and bit source together.
// Assumes: SYS_PERIOD_NS is the true period of clk; one 160-dot device.
module disp_wr_ctrl
    import disp_wr_pkg::*;
#(
    parameter int SYS_PERIOD_NS = 5,
    parameter int T_CLK_HI_NS   = 80,
    parameter int T_CLK_LO_NS   = 80,
    parameter int T_RS_SU_NS    = 10,
    parameter int T_RS_HD_NS    = 10,
    parameter int T_CE_SU_NS    = 35,
    parameter int T_CE_HD_NS    = 20,
    parameter int T_DIN_SU_NS   = 10,
    parameter int T_DIN_HD_NS   = 10,
    parameter int T_RST_NS      = 50,
    parameter int N_CHARS       = 4,
    parameter int CHAR_COLS     = 5,
    parameter int CHAR_ROWS     = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    input  logic [1:0]                            req_kind,
    input  logic [7:0]                            req_ctl,
    input  logic [N_CHARS*CHAR_COLS*CHAR_ROWS-1:0] req_cols,
    input  logic [3:0]                            bright,
    output logic                                  disp_rst_n,
    output logic                                  disp_rs,
    output logic                                  disp_ce_n,
    output logic                                  disp_clk,
    output logic                                  disp_din,
    output logic                                  busy,
    output logic                                  done
);

    localparam int N_COLS     = N_CHARS * CHAR_COLS;
    localparam int CTRL_BITS  = 8;
    localparam int LEN_RST    = ns_to_cyc(T_RST_NS, SYS_PERIOD_NS);
    localparam int LEN_RS_SU  = ns_to_cyc(T_RS_SU_NS, SYS_PERIOD_NS);
    localparam int LEN_CEFALL = imax(ns_to_cyc(T_CE_SU_NS, SYS_PERIOD_NS),
                                     ns_to_cyc(T_RS_HD_NS, SYS_PERIOD_NS));
    localparam int LEN_LO     = imax(ns_to_cyc(T_CLK_LO_NS, SYS_PERIOD_NS),
                                     ns_to_cyc(T_DIN_SU_NS, SYS_PERIOD_NS));
    localparam int LEN_HI     = imax(ns_to_cyc(T_CLK_HI_NS, SYS_PERIOD_NS),
                                     imax(ns_to_cyc(T_CE_HD_NS, SYS_PERIOD_NS),
                                          ns_to_cyc(T_DIN_HD_NS, SYS_PERIOD_NS)));
    localparam int LEN_CERISE = ns_to_cyc(T_CE_HD_NS, SYS_PERIOD_NS);
    localparam int LEN_MAX    = imax(imax(LEN_RST, LEN_CEFALL),
                                     imax(imax(LEN_LO, LEN_HI), LEN_RS_SU));
    localparam int TW         = $clog2(LEN_MAX + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    logic          src_load;
    src_mode_t     src_mode;
    logic [7:0]    src_byte;
    logic          src_shift;
    logic          src_bit;
    logic          src_bit_next;
    logic          src_last;

    disp_wr_seq #(
        .TW         (TW),
        .LEN_RST    (LEN_RST),
        .LEN_RS_SU  (LEN_RS_SU),
        .LEN_CEFALL (LEN_CEFALL),
        .LEN_LO     (LEN_LO),
        .LEN_HI     (LEN_HI),
        .LEN_CERISE (LEN_CERISE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind_t'(req_kind)),
        .req_ctl      (req_ctl),
        .bright       (bright),
        .tmr_expired  (tmr_expired),
        .src_bit      (src_bit),
        .src_bit_next (src_bit_next),
        .src_last     (src_last),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .src_load     (src_load),
        .src_mode     (src_mode),
        .src_byte     (src_byte),
        .src_shift    (src_shift),
        .disp_rst_n   (disp_rst_n),
        .disp_rs      (disp_rs),
        .disp_ce_n    (disp_ce_n),
        .disp_clk     (disp_clk),
        .disp_din     (disp_din),
        .busy         (busy),
        .done         (done)
    );

    disp_wr_timer #(
        .TW (TW)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    disp_wr_bitsrc #(
        .N_COLS    (N_COLS),
        .ROWS      (CHAR_ROWS),
        .CTRL_BITS (CTRL_BITS)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (src_load),
        .mode     (src_mode),
        .ctl_byte (src_byte),
        .cols     (req_cols),
        .shift    (src_shift),
        .bit_out  (src_bit),
        .bit_next (src_bit_next),
        .last     (src_last)
    );

endmodule

// File: rtl/disp_wr_chk.sv
// Checker for the serial display write controller: watches the port-level
// waveform every cycle. Phase widths are measured with run counters.
// Assumes: attached by the bind at the end of this file.
module disp_wr_chk #(
    parameter int MIN_HI    = 16,
    parameter int MIN_LO    = 16,
    parameter int MIN_CE_SU = 7
) (
    input logic clk,
    input logic rst_n,
    input logic disp_rst_n,
    input logic disp_rs,
    input logic disp_ce_n,
    input logic disp_clk,
    input logic disp_din,
    input logic busy,
    input logic done
);

    logic [15:0] hi_run;
    logic [15:0] lo_run;
    logic [15:0] ce_run;

    // Run lengths of serial clock high, serial clock low and enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
            ce_run <= '0;
        end else begin
            hi_run <= disp_clk  ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= !disp_clk ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : '0;
            ce_run <= !disp_ce_n ? ((ce_run == 16'hFFFF) ? ce_run : ce_run + 1'b1) : '0;
        end
    end

    AST_RST_KEEPS_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> disp_ce_n); // R2
    AST_RS_STABLE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ce_n && !$past(disp_ce_n)) |-> $stable(disp_rs)); // R3
    AST_CE_SETUP_TO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(disp_clk) && !disp_ce_n) |-> (ce_run >= 16'(MIN_CE_SU))); // R4
    AST_CLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_clk) |-> (hi_run >= 16'(MIN_HI))); // R5
    AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_clk) |-> (lo_run >= 16'(MIN_LO))); // R5
    AST_DIN_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_din) |-> !disp_clk); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

endmodule

bind disp_wr_ctrl disp_wr_chk #(
    .MIN_HI    (LEN_HI),
    .MIN_LO    (LEN_LO),
    .MIN_CE_SU (LEN_CEFALL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_rst_n (disp_rst_n),
    .disp_rs    (disp_rs),
    .disp_ce_n  (disp_ce_n),
    .disp_clk   (disp_clk),
    .disp_din   (disp_din),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_disp_wr_ctrl.sv
`timescale 1ns/1ps
module sim_disp_wr_ctrl;

    localparam int PER      = 5;
    localparam int EXP_HI   = (80 + PER - 1) / PER;
    localparam int EXP_LO   = (80 + PER - 1) / PER;
    localparam int EXP_CESU = (35 + PER - 1) / PER;
    localparam int EXP_CEHD = (20 + PER - 1) / PER;
    localparam int EXP_RSSU = (10 + PER - 1) / PER;
    localparam int EXP_RST  = (50 + PER - 1) / PER;
    localparam int NB       = 160;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic [1:0]     req_kind;
    logic [7:0]     req_ctl;
    logic [NB-1:0]  req_cols;
    logic [3:0]     bright;
    logic           disp_rst_n, disp_rs, disp_ce_n, disp_clk, disp_din, busy, done;

    always #2.5 clk = ~clk;

    disp_wr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ctl(req_ctl), .req_cols(req_cols), .bright(bright),
        .disp_rst_n(disp_rst_n), .disp_rs(disp_rs), .disp_ce_n(disp_ce_n),
        .disp_clk(disp_clk), .disp_din(disp_din), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [NB-1:0] act,
                       input logic [NB-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Wire-level monitor state
    logic          p_clk = 1'b1, p_ce = 1'b1, p_rstn = 1'b0, p_rs = 1'b0, p_din = 1'b0;
    int            hi_run = 0, lo_run = 0, ce_run = 0, rs_run = 0, since_rise = 0;
    int            rlow = 0, last_rlow = 0, idx = 0, nw = 0, nlatch = 0;
    int            done_run = 0;
    int            v_rs = 0, v_ce = 0, v_clk = 0, v_din = 0, v_done = 0, v_idle = 0;
    logic          ce_rs = 1'b0;
    logic [NB-1:0] cur = '0;
    logic [NB-1:0] wr_bits [0:31];
    int            wr_len  [0:31];
    logic          wr_rs   [0:31];

    // Decode the serial port mid-cycle and track phase widths.
    always @(negedge clk) begin
        if (rst_n) begin
            if (disp_clk && !p_clk) begin
                if (lo_run < EXP_LO) v_clk++;
                if (!disp_ce_n) begin
                    if (idx == 0 && ce_run < EXP_CESU) v_ce++;
                    if (idx < NB) cur[idx] = disp_din;
                    idx++;
                    since_rise = 0;
                end
            end
            if (!disp_clk && p_clk) begin
                if (hi_run < EXP_HI) v_clk++;
                if (disp_ce_n) nlatch++;
                if (!busy) v_idle++;
            end
            if (disp_din != p_din && disp_clk) v_din++;
            if (!disp_ce_n && p_ce) begin
                if (rs_run < EXP_RSSU) v_rs++;
                idx = 0;
                cur = '0;
                ce_rs = disp_rs;
            end
            if (!disp_ce_n && !p_ce && disp_rs != ce_rs) v_rs++;
            if (disp_ce_n && !p_ce) begin
                if (since_rise < EXP_CEHD) v_ce++;
                if (nw < 32) begin
                    wr_bits[nw] = cur;
                    wr_len[nw]  = idx;
                    wr_rs[nw]   = ce_rs;
                end
                nw++;
            end
            if (!disp_rst_n) rlow++;
            if (disp_rst_n && !p_rstn) begin
                last_rlow = rlow;
                rlow = 0;
            end
            if (done) begin
                done_run++;
                if (busy) v_done++;
            end else begin
                done_run = 0;
            end
            if (done_run > 1) v_done++;
            hi_run     = disp_clk ? hi_run + 1 : 0;
            lo_run     = disp_clk ? 0 : lo_run + 1;
            ce_run     = disp_ce_n ? 0 : ce_run + 1;
            rs_run     = (disp_rs != p_rs) ? 1 : rs_run + 1;
            since_rise = since_rise + 1;
        end
        p_clk  = disp_clk;
        p_ce   = disp_ce_n;
        p_rstn = disp_rst_n;
        p_rs   = disp_rs;
        p_din  = disp_din;
    end

    function automatic logic [NB-1:0] exp_ctrl(input logic [7:0] b);
        logic [NB-1:0] v = '0;
        for (int k = 0; k < 8; k++) v[k] = b[7-k];
        return v;
    endfunction

    function automatic logic [NB-1:0] exp_frame(input logic [NB-1:0] f);
        logic [NB-1:0] v;
        for (int k = 0; k < NB; k++) v[k] = f[(k/8)*8 + 7 - (k%8)];
        return v;
    endfunction

    function automatic logic [NB-1:0] mk_frame(input int p);
        logic [NB-1:0] f = '0;
        for (int c = 0; c < 20; c++) begin
            case (p)
                0: f[c*8 +: 8] = 8'hFF;
                1: f[c*8 +: 8] = 8'((c * 37 + 11) % 256);
                2: f[c*8 +: 8] = (c == 0) ? 8'h02 : 8'h00;
                default: f[c*8 +: 8] = 8'(1 << (c % 8));
            endcase
        end
        return f;
    endfunction

    task automatic send(input logic [1:0] kind, input logic [7:0] b,
                        input logic [NB-1:0] f, input bit expect_busy);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_ctl   = b;
        req_cols  = f;
        @(negedge clk);
        req_valid = 1'b0;
        req_kind  = 2'd3;
        if (expect_busy) chk(busy == 1'b1, "R11 busy after accept", NB'(busy), NB'(1));
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [NB-1:0] f;
        logic [7:0] cb [0:3];
        cb[0] = 8'h81; cb[1] = 8'h4F; cb[2] = 8'h00; cb[3] = 8'hFE;
        rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd3; req_ctl = '0;
        req_cols = '0; bright = 4'hA;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(disp_rst_n == 1'b0, "R1 disp_rst_n", NB'(disp_rst_n), NB'(0));
        chk(disp_ce_n == 1'b1 && disp_clk == 1'b1, "R1 ce_n/clk",
            NB'({disp_ce_n, disp_clk}), NB'(3));
        chk(done == 1'b0 && busy == 1'b1, "R1 done/busy", NB'({done, busy}), NB'(1));
        rst_n = 1'b1;
        wait_done();
        // R2: start-up pulse and writes
        chk(last_rlow >= EXP_RST, "R2 reset pulse length", NB'(last_rlow), NB'(EXP_RST));
        chk(nw == 2, "R2 start-up write count", NB'(nw), NB'(2));
        chk(wr_rs[0] == 1'b0 && wr_len[0] == NB && wr_bits[0] == '0, "R2 dot clear",
            wr_bits[0], '0);
        chk(wr_rs[1] == 1'b1 && wr_len[1] == 8, "R2 control write shape",
            NB'(wr_len[1]), NB'(8));
        chk(wr_bits[1] == exp_ctrl({4'b0100, 4'hA}), "R2 control word 0 value",
            wr_bits[1], exp_ctrl({4'b0100, 4'hA}));
        // R8: frames
        for (int p = 0; p < 4; p++) begin
            base = nw;
            f = mk_frame(p);
            send(2'd2, 8'h00, f, 1'b1);
            wait_done();
            chk(nw == base + 1 && wr_rs[base] == 1'b0 && wr_len[base] == NB,
                "R8 frame write shape", NB'(wr_len[base]), NB'(NB));
            chk(wr_bits[base] == exp_frame(f), "R8 frame bit order",
                wr_bits[base], exp_frame(f));
        end
        // R9: control bytes
        for (int i = 0; i < 4; i++) begin
            base = nw;
            send(2'd1, cb[i], '0, 1'b1);
            wait_done();
            chk(nw == base + 1 && wr_rs[base] == 1'b1 && wr_len[base] == 8,
                "R9 control write shape", NB'(wr_len[base]), NB'(8));
            chk(wr_bits[base] == exp_ctrl(cb[i]), "R9 control MSB first",
                wr_bits[base], exp_ctrl(cb[i]));
        end
        // R10: request while busy is dropped
        base = nw;
        f = mk_frame(1);
        send(2'd2, 8'h00, f, 1'b1);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_ctl = 8'h55;
        repeat (2) @(negedge clk);
        req_valid = 1'b0; req_kind = 2'd3;
        wait_done();
        repeat (200) @(negedge clk);
        chk(nw == base + 1, "R10 busy request dropped", NB'(nw - base), NB'(1));
        chk(wr_bits[base] == exp_frame(f), "R10 frame intact", wr_bits[base], exp_frame(f));
        // R10: no-op kind starts nothing
        base = nw;
        send(2'd3, 8'h00, '0, 1'b0);
        chk(busy == 1'b0, "R10 no-op stays idle", NB'(busy), NB'(0));
        repeat (100) @(negedge clk);
        chk(nw == base && busy == 1'b0, "R10 no-op no write", NB'(nw - base), NB'(0));
        // R12: re-initialise with new brightness
        base = nw;
        bright = 4'h5;
        send(2'd0, 8'h00, '0, 1'b1);
        bright = 4'hC;
        wait_done();
        chk(last_rlow >= EXP_RST, "R12 reset pulse again", NB'(last_rlow), NB'(EXP_RST));
        chk(nw == base + 2 && wr_bits[base] == '0 && wr_len[base] == NB,
            "R12 dot clear again", NB'(nw - base), NB'(2));
        chk(wr_bits[base+1] == exp_ctrl(8'h45), "R12 captured brightness",
            wr_bits[base+1], exp_ctrl(8'h45));
        // Waveform-rule tallies
        chk(v_rs == 0, "R3 select setup/stability", NB'(v_rs), '0);
        chk(v_ce == 0, "R4 enable setup/hold", NB'(v_ce), '0);
        chk(v_clk == 0, "R5 clock phase widths", NB'(v_clk), '0);
        chk(v_din == 0, "R6 data moves only low", NB'(v_din), '0);
        chk(nlatch == nw && v_idle == 0, "R7 one latch per write", NB'(nlatch), NB'(nw));
        chk(v_done == 0, "R11 done shape", NB'(v_done), '0);
        summary();
        $finish;
    end

endmodule